// File: doc/BRIEF.md
# Masked-Compare Repeating Interrupt Timer

A free-running up-counter, 48 bits wide by default, is compared every clock against a compare value, with the bits set in a mask register left out of the comparison. When the remaining bits agree, a sticky interrupt flag is raised on the next clock edge. It stays up until software writes a one to it. A control bit can also make each match send the counter back to zero, which turns the block into a periodic tick source whose period is the compare value plus one.

Software reaches the block through a plain write/read port. Each wide value sits behind two addresses: a 32-bit low word and a 16-bit high word. One control word holds the flag, the clear-on-match bit and the enable bit. The interrupt output follows the flag level. If every mask bit is set, the comparison is always satisfied, so software can raise the interrupt at once without disturbing the count.

Top module: `mrt_timer`

## Requirements
- R1: After reset the counter, the mask and the control word read as zero, the compare value reads as all ones, and `irq` is low.
- R2: While the enable bit (control bit 2) is clear, the counter keeps its value.
- R3: While enabled, the counter goes up by one per clock. When there is no clear on match, it moves from all ones to zero.
- R4: A match means that `((counter ^ compare) & ~mask) == 0`. A match sets the flag (control bit 0) on the next clock edge, whether or not counting is enabled.
- R5: With every mask bit set, the flag rises at once. When clear-on-match is off, the counter keeps counting.
- R6: When the clear-on-match bit (control bit 1) and the enable bit are both set, a match loads zero into the counter on the next edge. The counter therefore cycles through 0 to the compare value.
- R7: The flag is sticky. Writing a control word with bit 0 at one clears it. Writing bit 0 at zero leaves it alone. A match in the same cycle as the clearing write leaves the flag set.
- R8: A software write to either counter word takes effect on the next edge, ahead of both the increment and the clear on match.
- R9: The address map is 0 control, 1 compare low, 2 compare high, 3 mask low, 4 mask high, 5 counter low, 6 counter high, and 7 reads zero. High words use write-data bits 15:0, and every register reads back what was written.
- R10: `irq` equals the flag bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt level, equal to the sticky flag |

## Verification
Two pairs of functions can fall on the same edge: a write-one-to-clear with a fresh match, and a counter write with an enabled increment. For the first pair, the bench holds a full mask so that every edge matches, then issues the clearing write and expects `irq` to stay high. A second clearing write with no match present must then bring it low. For the second pair, the bench writes the counter while it is running and predicts the value from the number of enabled edges after the write, so the written value must not have been incremented. A near-exhaustive sweep of 4-bit counter, compare and mask patterns checks the masked-equality rule against arithmetic computed in the bench.

// File: rtl/mrt_timer.sv
module mrt_timer #(
  parameter int CNT_W = 48,
  parameter int LO_W  = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [2:0]      addr,
  input  logic [LO_W-1:0] wdata,
  output logic [LO_W-1:0] rdata,
  output logic            irq
);
  localparam int HI_W = CNT_W - LO_W;
  localparam logic [2:0] A_CTRL = 3'd0, A_CMPL = 3'd1, A_CMPH = 3'd2,
                         A_MSKL = 3'd3, A_MSKH = 3'd4, A_CNTL = 3'd5,
                         A_CNTH = 3'd6;

  logic [CNT_W-1:0] cnt, cmp, msk;
  logic             flag, clr_on, run;

  wire wr_ctrl = wr_en && addr == A_CTRL;
  wire wr_cntl = wr_en && addr == A_CNTL;
  wire wr_cnth = wr_en && addr == A_CNTH;
  wire wr_cnt  = wr_cntl || wr_cnth;
  wire hit     = ((cnt ^ cmp) & ~msk) == '0;
  wire ack     = wr_ctrl && wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (wr_cntl) begin
      cnt[LO_W-1:0] <= wdata;
    end else if (wr_cnth) begin
      cnt[CNT_W-1:LO_W] <= wdata[HI_W-1:0];
    end else if (run) begin
      cnt <= (hit && clr_on) ? '0 : cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp <= '1;
      msk <= '0;
    end else if (wr_en) begin
      case (addr)
        A_CMPL:  cmp[LO_W-1:0]     <= wdata;
        A_CMPH:  cmp[CNT_W-1:LO_W] <= wdata[HI_W-1:0];
        A_MSKL:  msk[LO_W-1:0]     <= wdata;
        A_MSKH:  msk[CNT_W-1:LO_W] <= wdata[HI_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag   <= 1'b0;
      clr_on <= 1'b0;
      run    <= 1'b0;
    end else begin
      flag <= hit || (flag && !ack);
      if (wr_ctrl) begin
        clr_on <= wdata[1];
        run    <= wdata[2];
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL: rdata[2:0]      = {run, clr_on, flag};
      A_CMPL: rdata           = cmp[LO_W-1:0];
      A_CMPH: rdata[HI_W-1:0] = cmp[CNT_W-1:LO_W];
      A_MSKL: rdata           = msk[LO_W-1:0];
      A_MSKH: rdata[HI_W-1:0] = msk[CNT_W-1:LO_W];
      A_CNTL: rdata           = cnt[LO_W-1:0];
      A_CNTH: rdata[HI_W-1:0] = cnt[CNT_W-1:LO_W];
      default: rdata = '0;
    endcase
  end

  assign irq = flag;

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_cnt) |=> $stable(cnt));
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wr_cnt && !(hit && clr_on)) |=> cnt == $past(cnt) + CNT_W'(1));
  p_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> irq);
  p_full_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (msk == '1) |=> irq);
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && clr_on && hit && !wr_cnt) |=> cnt == '0);
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack) |=> irq);
  p_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !hit) |=> !irq);
  p_wr_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cntl |=> cnt[LO_W-1:0] == $past(wdata));
endmodule

// File: tb/sim_mrt_timer.sv
`timescale 1ns/1ps
module sim_mrt_timer;
  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [2:0]  addr = 3'd7;
  logic [31:0] wdata = '0, rdata;
  logic        irq;
  int n_chk = 0, n_bad = 0;

  mrt_timer u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                .wdata(wdata), .rdata(rdata), .irq(irq));

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 3'd7;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdata;
  endtask

  // enabled for k+2 rising edges
  task automatic run_for(input logic [31:0] on, input logic [31:0] off, input int k);
    wr(3'd0, on);
    repeat (k) @(negedge clk);
    wr(3'd0, off);
  endtask

  initial begin
    #1_500_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    rd(3'd0, v); chk("R1 ctrl", v, 32'h0);
    rd(3'd1, v); chk("R1 cmp lo", v, 32'hffff_ffff);
    rd(3'd2, v); chk("R1 cmp hi", v, 32'h0000_ffff);
    rd(3'd3, v); chk("R1 mask lo", v, 32'h0);
    rd(3'd5, v); chk("R1 cnt lo", v, 32'h0);
    chk("R1 R10 irq", {31'd0, irq}, 32'h0);
    // R9 register map readback
    wr(3'd1, 32'h0001_2345); wr(3'd2, 32'h0);
    wr(3'd4, 32'hdead_00a5); rd(3'd4, v); chk("R9 mask hi", v, 32'h0000_00a5);
    wr(3'd4, 32'h0);
    rd(3'd7, v); chk("R9 addr7", v, 32'h0);
    // R2 hold while disabled
    wr(3'd5, 32'd100);
    repeat (8) @(negedge clk);
    rd(3'd5, v); chk("R2 hold", v, 32'd100);
    // R3 counting
    run_for(32'h4, 32'h0, 7);
    rd(3'd5, v); chk("R3 count", v, 32'd109);
    run_for(32'h4, 32'h0, 30);
    rd(3'd5, v); chk("R3 count2", v, 32'd141);
    // R3 wrap
    wr(3'd5, 32'hffff_fffe); wr(3'd6, 32'h0000_ffff);
    run_for(32'h4, 32'h0, 3);
    rd(3'd5, v); chk("R3 wrap lo", v, 32'd3);
    rd(3'd6, v); chk("R3 wrap hi", v, 32'd0);
    // R8 counter write while running wins over increment
    wr(3'd0, 32'h4);
    wr(3'd5, 32'd500);
    wr(3'd0, 32'h0);
    rd(3'd5, v); chk("R8 priority", v, 32'd502);
    // R6 clear on match: period compare+1
    wr(3'd5, 32'd0); wr(3'd1, 32'd9); wr(3'd0, 32'h1);
    run_for(32'h6, 32'h2, 21);
    rd(3'd5, v); chk("R6 cycle", v, 32'd3);
    chk("R6 irq", {31'd0, irq}, 32'h1);
    // R5 full mask, counting continues
    wr(3'd1, 32'h0001_2345); wr(3'd5, 32'd0);
    wr(3'd3, 32'hffff_ffff); wr(3'd4, 32'h0000_ffff);
    run_for(32'h4, 32'h0, 10);
    chk("R5 irq", {31'd0, irq}, 32'h1);
    rd(3'd5, v); chk("R5 count", v, 32'd12);
    // R7 clear concurrent with match keeps flag
    wr(3'd0, 32'h1);
    chk("R7 clear vs match", {31'd0, irq}, 32'h1);
    wr(3'd1, 32'd12); wr(3'd3, 32'h0); wr(3'd4, 32'h0);
    wr(3'd1, 32'h0001_2345);
    wr(3'd0, 32'h0);
    rd(3'd0, v); chk("R7 write zero keeps", v, 32'h1);
    wr(3'd0, 32'h1);
    chk("R7 clear", {31'd0, irq}, 32'h0);
    rd(3'd0, v); chk("R7 R10 ctrl", v, 32'h0);
    // R4 masked equality sweep
    wr(3'd6, 32'h0);
    for (int c = 0; c < 16; c++) begin
      wr(3'd5, c);
      for (int m = 0; m < 16; m++) begin
        wr(3'd3, m);
        for (int cv = 0; cv < 16; cv++) begin
          logic e;
          wr(3'd1, cv);
          wr(3'd0, 32'h1);
          @(negedge clk);
          e = ((c ^ cv) & ~m & 15) == 0;
          chk($sformatf("R4 c=%0d v=%0d m=%0d", c, cv, m), {31'd0, irq}, {31'd0, e});
        end
      end
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule